// File: doc/BRIEF.md
# Page Write Engine with Status Polling

This block is the write path of a byte-wide electrically erasable memory, modelled as synchronous logic. Single-cycle write strobes carry an address and a data byte. The first write opens a load period and fixes the page. Each accepted byte goes into a 128-entry staging buffer, and the buffer marks that entry as loaded. The load period closes when no byte is accepted for a set number of cycles. The engine then enters a programming period of fixed length. During that period it copies each loaded entry, one per cycle, into an internal array that stands in for the nonvolatile cells.

While programming is under way, `busy` is high. A read in this period returns a status word instead of array data. In the status word, bit 7 is the inverse of the last byte written, and bit 6 alternates from one read to the next. Software can poll either bit to find the end of the period. Outside programming, a read returns the stored byte. A write that targets a page other than the one being loaded is dropped and sets a sticky error flag.

The load window, the programming time and the array depth are parameters counted in clock cycles or bytes.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy`, `page_err` and `rdata` are 0, and every array location reads as the erased value 0xFF.
- R2: Address bits [6:0] select the byte inside a page and bits [16:7] form the page number. The array keeps only the low page bits, so with 1024 bytes page 9 and page 1 are the same storage.
- R3: A write while idle or loading is stored in the staging buffer. Bytes may arrive in any order, and a later byte to the same offset replaces the earlier one.
- R4: Loading continues while each write lands no more than `LOAD_WIN` cycles after the previous accepted write. After `LOAD_WIN` cycles with no accepted write, `busy` rises. `busy` stays low while loading.
- R5: During loading, a write whose page differs from the page of the first byte is ignored and sets `page_err`. `page_err` then stays set until reset.
- R6: `busy` stays high for exactly `PROG_CYCLES` cycles. Writes during that time change nothing and do not set `page_err`.
- R7: Only offsets loaded in the period are programmed. Other bytes of the page keep their contents.
- R8: A read during programming returns, one cycle later, the inverse of bit 7 of the last accepted byte in bit 7, and that byte's bits [5:0] in bits [5:0].
- R9: Bit 6 of the status word is 0 on the first read of a programming period and alternates on each later read in that period.
- R10: Outside programming, a read returns the array byte one cycle later. `rdata` holds its value in cycles without a read.
- R11: When programming ends, every loaded mark is cleared. A later period on another page does not rewrite offsets it did not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 17 | Byte address: page in [16:7], offset in [6:0] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status word, registered |
| busy | output | 1 | High during the programming period |
| page_err | output | 1 | Sticky flag for a dropped write to a foreign page |

## Verification
The bench tests the load-window boundary. A byte arriving on the last allowed cycle must be kept, and one cycle later `busy` must rise. A design with an off-by-one counter either starts programming early or accepts a late byte. The bench counts the high cycles of `busy`, and it reads the polling word several times to confirm the inverted bit 7 and a bit 6 that starts at 0. It writes during programming and to a foreign page, and confirms that neither write reaches the array. It then runs a period on a fresh page, where a design that keeps old loaded marks would copy stale buffer bytes into offsets that were never loaded.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } eepw_state_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eepw_timer.sv
module eepw_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;

   assign hit = (cnt_q == (limit - 1'b1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (!hit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
   parameter  int unsigned DATA_W     = 8,
   parameter  int unsigned PAGE_BYTES = 128,
   localparam int unsigned OFS_W      = $clog2(PAGE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_en,
   input  logic [OFS_W-1:0]      ld_ofs,
   input  logic [DATA_W-1:0]     ld_data,
   input  logic                  clr_all,
   input  logic [OFS_W-1:0]      rd_ofs,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_vld,
   output logic [PAGE_BYTES-1:0] vld_mask
);

   logic [DATA_W-1:0] slot_q [PAGE_BYTES];

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic hit_w;
      assign hit_w = ld_en && (ld_ofs == OFS_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[g] <= '0;
         end else if (hit_w) begin
            slot_q[g] <= ld_data;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_mask[g] <= 1'b0;
         end else if (clr_all) begin
            vld_mask[g] <= 1'b0;
         end else if (hit_w) begin
            vld_mask[g] <= 1'b1;
         end
      end
   end

   assign rd_data = slot_q[rd_ofs];
   assign rd_vld  = vld_mask[rd_ofs];

endmodule

// File: rtl/eepw_cell_array.sv
module eepw_cell_array #(
   parameter  int unsigned     DATA_W = 8,
   parameter  int unsigned     DEPTH  = 1024,
   parameter  logic [DATA_W-1:0] ERASED = '1,
   localparam int unsigned     AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cell_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            cell_q[i] <= ERASED;
         end
      end else if (we) begin
         cell_q[waddr] <= wdata;
      end
   end

   assign rdata = cell_q[raddr];

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
   import eepw_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 17,
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       PAGE_BYTES  = 128,
   parameter int unsigned       ARRAY_DEPTH = 1024,
   parameter int unsigned       LOAD_WIN    = 16,
   parameter int unsigned       PROG_CYCLES = 200,
   parameter logic [DATA_W-1:0] ERASED      = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic              page_err
);

   localparam int unsigned OFS_W   = $clog2(PAGE_BYTES);
   localparam int unsigned PAGE_W  = ADDR_W - OFS_W;
   localparam int unsigned ARR_AW  = $clog2(ARRAY_DEPTH);
   localparam int unsigned APAGE_W = ARR_AW - OFS_W;
   localparam int unsigned TMR_MAX = max_u(LOAD_WIN, PROG_CYCLES);
   localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

   // elaboration-time parameter checks
   if ((1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if ((1 << ARR_AW) != ARRAY_DEPTH || ARRAY_DEPTH < PAGE_BYTES) begin : g_bad_depth
      $error("ARRAY_DEPTH must be a power of two of at least one page");
   end
   if (ADDR_W < ARR_AW) begin : g_bad_addr
      $error("ADDR_W too narrow for ARRAY_DEPTH");
   end
   if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_prog
      $error("PROG_CYCLES must cover one commit cycle per page byte");
   end
   if (LOAD_WIN < 1) begin : g_bad_win
      $error("LOAD_WIN must be at least one cycle");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold the two status bits");
   end

   eepw_state_e         state_q, state_d;
   logic [PAGE_W-1:0]   page_q;
   logic [DATA_W-1:0]   last_q;
   logic [OFS_W:0]      ptr_q;
   logic                tog_q;
   logic                err_q;
   logic [DATA_W-1:0]   rdata_q;

   logic [OFS_W-1:0]    ofs;
   logic [PAGE_W-1:0]   pg;
   logic                page_ok;
   logic                load_acc;
   logic                page_miss;
   logic                tmr_clr;
   logic                tmr_hit;
   logic [TMR_W-1:0]    tmr_limit;
   logic                enter_prog;
   logic                leave_prog;
   logic                commit_live;
   logic [OFS_W-1:0]    commit_ofs;
   logic [DATA_W-1:0]   buf_rdata;
   logic                buf_rvld;
   logic [PAGE_BYTES-1:0] buf_mask;
   logic                cell_we;
   logic [ARR_AW-1:0]   arr_waddr;
   logic [ARR_AW-1:0]   arr_raddr;
   logic [DATA_W-1:0]   arr_rdata;
   logic [DATA_W-1:0]   poll_word;

   assign ofs       = addr[OFS_W-1:0];
   assign pg        = addr[ADDR_W-1:OFS_W];
   assign page_ok   = (pg == page_q);
   assign load_acc  = wr_en && ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && page_ok));
   assign page_miss = wr_en && (state_q == ST_LOAD) && !page_ok;

   assign enter_prog = (state_q == ST_LOAD) && !load_acc && tmr_hit;
   assign leave_prog = (state_q == ST_PROG) && tmr_hit;
   assign tmr_clr    = (state_q == ST_IDLE) || load_acc || enter_prog || leave_prog;
   assign tmr_limit  = (state_q == ST_PROG) ? TMR_W'(PROG_CYCLES) : TMR_W'(LOAD_WIN);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (load_acc)   state_d = ST_LOAD;
         ST_LOAD: if (enter_prog) state_d = ST_PROG;
         ST_PROG: if (leave_prog) state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   eepw_timer #(
      .CNT_W (TMR_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .limit (tmr_limit),
      .hit   (tmr_hit)
   );

   assign commit_live = !ptr_q[OFS_W];
   assign commit_ofs  = ptr_q[OFS_W-1:0];

   eepw_page_buf #(
      .DATA_W     (DATA_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (load_acc),
      .ld_ofs   (ofs),
      .ld_data  (wdata),
      .clr_all  (leave_prog),
      .rd_ofs   (commit_ofs),
      .rd_data  (buf_rdata),
      .rd_vld   (buf_rvld),
      .vld_mask (buf_mask)
   );

   assign cell_we = (state_q == ST_PROG) && commit_live && buf_rvld;

   // array addressing: single-page arrays ignore the page number
   if (APAGE_W > 0) begin : g_multi_page
      assign arr_waddr = {page_q[APAGE_W-1:0], commit_ofs};
      assign arr_raddr = {addr[OFS_W+APAGE_W-1:OFS_W], ofs};
   end else begin : g_single_page
      assign arr_waddr = commit_ofs;
      assign arr_raddr = ofs;
   end

   eepw_cell_array #(
      .DATA_W (DATA_W),
      .DEPTH  (ARRAY_DEPTH),
      .ERASED (ERASED)
   ) u_cells (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cell_we),
      .waddr (arr_waddr),
      .wdata (buf_rdata),
      .raddr (arr_raddr),
      .rdata (arr_rdata)
   );

   always_comb begin
      poll_word    = last_q;
      poll_word[7] = ~last_q[7];
      poll_word[6] = tog_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         page_q  <= '0;
         last_q  <= '0;
         ptr_q   <= '0;
         tog_q   <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (load_acc) begin
            page_q <= pg;
            last_q <= wdata;
         end
         if (page_miss) begin
            err_q <= 1'b1;
         end
         if (enter_prog) begin
            ptr_q <= '0;
            tog_q <= 1'b0;
         end else if ((state_q == ST_PROG) && commit_live) begin
            ptr_q <= ptr_q + 1'b1;
         end
         if (rd_en) begin
            if (state_q == ST_PROG) begin
               rdata_q <= poll_word;
               tog_q   <= ~tog_q;
            end else begin
               rdata_q <= arr_rdata;
            end
         end
      end
   end

   assign rdata    = rdata_q;
   assign busy     = (state_q == ST_PROG);
   assign page_err = err_q;

endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_BYTES = 128
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  busy,
   input logic                  page_err,
   input logic                  rd_en,
   input logic [DATA_W-1:0]     rdata,
   input logic [DATA_W-1:0]     last_byte,
   input logic                  load_acc,
   input logic                  page_miss,
   input logic                  cell_we,
   input logic [PAGE_BYTES-1:0] mask
);

   // R4: an accepted byte keeps the engine out of programming
   a_r4_accept_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      load_acc |=> !busy);

   // R5: a foreign-page write raises the flag
   a_r5_miss_flags: assert property (@(posedge clk) disable iff (!rst_n)
      page_miss |=> page_err);

   // R5: the flag never drops before reset
   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      page_err |=> page_err);

   // R6: no byte enters the buffer while programming
   a_r6_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !load_acc);

   // R7: the array changes only inside the programming period
   a_r7_commit_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
      cell_we |-> busy);

   // R8: status read carries the inverted top bit
   a_r8_poll_bit7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> (rdata[7] != last_byte[7]));

   // R11: the loaded marks are empty once programming ends
   a_r11_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (mask == '0));

endmodule

bind eeprom_page_writer eepw_checker #(
   .DATA_W     (DATA_W),
   .PAGE_BYTES (PAGE_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .page_err  (page_err),
   .rd_en     (rd_en),
   .rdata     (rdata),
   .last_byte (last_q),
   .load_acc  (load_acc),
   .page_miss (page_miss),
   .cell_we   (cell_we),
   .mask      (buf_mask)
);

// File: tb/eeprom_page_writer_tb.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb;

   localparam int unsigned LOAD_WIN    = 16;
   localparam int unsigned PROG_CYCLES = 200;

   localparam logic [1:0] OP_WR   = 2'd0;
   localparam logic [1:0] OP_RD   = 2'd2;
   localparam logic [1:0] OP_DONE = 2'd3;

   // {op, addr, data}; for reads the data field is the expected byte
   localparam int unsigned NVEC = 11;
   localparam logic [26:0] VEC [NVEC] = '{
      {OP_WR,   17'h00105, 8'hA5},
      {OP_WR,   17'h00103, 8'h3C},
      {OP_WR,   17'h00105, 8'h5A},
      {OP_WR,   17'h0017F, 8'h81},
      {OP_RD,   17'h00105, 8'hFF},
      {OP_DONE, 17'h00000, 8'h00},
      {OP_RD,   17'h00105, 8'h5A},
      {OP_RD,   17'h00103, 8'h3C},
      {OP_RD,   17'h0017F, 8'h81},
      {OP_RD,   17'h00104, 8'hFF},
      {OP_RD,   17'h00100, 8'hFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        busy;
   logic        page_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   eeprom_page_writer #(
      .LOAD_WIN    (LOAD_WIN),
      .PROG_CYCLES (PROG_CYCLES)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .busy     (busy),
      .page_err (page_err)
   );

   function automatic logic [16:0] mk(input int unsigned page, input int unsigned ofs);
      return {page[9:0], ofs[6:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [16:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [16:0] a, output logic [7:0] v);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_done();
      for (int i = 0; i < LOAD_WIN + 4 && !busy; i++) @(negedge clk);
      for (int i = 0; i < PROG_CYCLES + 4 && busy; i++) @(negedge clk);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int cnt;
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", {31'b0, busy}, 32'd0);
      chk("R1 page_err", {31'b0, page_err}, 32'd0);
      chk("R1 rdata", {24'b0, rdata}, 32'd0);
      rd(mk(0, 0), v);
      chk("R1 erased", {24'b0, v}, 32'hFF);

      // table walk: R3 out-of-order load with overwrite, R7, R10
      for (int i = 0; i < NVEC; i++) begin
         logic [1:0]  op;
         logic [16:0] va;
         logic [7:0]  vd;
         {op, va, vd} = VEC[i];
         case (op)
            OP_WR:   wr(va, vd);
            OP_RD:   begin rd(va, v); chk("R3 R7 R10 table read", {24'b0, v}, {24'b0, vd}); end
            default: wait_done();
         endcase
      end

      // R4 window edge, R8/R9 polling, R6 duration and ignored writes
      wr(mk(5, 0), 8'h4C);
      wr(mk(5, 1), 8'hC3);
      idle(LOAD_WIN - 1);
      chk("R4 not busy before window end", {31'b0, busy}, 32'd0);
      idle(1);
      chk("R4 busy after window", {31'b0, busy}, 32'd1);
      cnt = 1;
      rd(mk(5, 1), v); cnt++;
      chk("R8 R9 first poll", {24'b0, v}, 32'h03);
      rd(mk(5, 1), v); cnt++;
      chk("R9 second poll toggles", {24'b0, v}, 32'h43);
      wr(mk(5, 2), 8'h77); cnt++;
      rd(mk(5, 1), v); cnt++;
      chk("R9 third poll", {24'b0, v}, 32'h03);
      while (busy && cnt < PROG_CYCLES + 10) begin
         @(negedge clk);
         if (busy) cnt++;
      end
      chk("R6 busy length", cnt, PROG_CYCLES);
      chk("R6 no error from busy write", {31'b0, page_err}, 32'd0);
      rd(mk(5, 1), v);
      chk("R8 true data after programming", {24'b0, v}, 32'hC3);
      rd(mk(5, 0), v);
      chk("R10 read first byte", {24'b0, v}, 32'h4C);
      idle(2);
      chk("R10 rdata holds", {24'b0, rdata}, 32'h4C);
      rd(mk(5, 2), v);
      chk("R6 write during programming ignored", {24'b0, v}, 32'hFF);

      // R4 byte on the last allowed cycle is kept; late byte dropped
      wr(mk(6, 0), 8'h10);
      idle(LOAD_WIN - 1);
      wr(mk(6, 1), 8'h11);
      chk("R4 last-cycle byte keeps loading", {31'b0, busy}, 32'd0);
      idle(LOAD_WIN);
      chk("R4 busy after second window", {31'b0, busy}, 32'd1);
      wr(mk(6, 2), 8'h22);
      wait_done();
      rd(mk(6, 1), v);
      chk("R4 last-cycle byte programmed", {24'b0, v}, 32'h11);
      rd(mk(6, 2), v);
      chk("R6 late byte not programmed", {24'b0, v}, 32'hFF);

      // R5 foreign page write
      wr(mk(1, 0), 8'h21);
      wr(mk(3, 1), 8'h99);
      chk("R5 page_err set", {31'b0, page_err}, 32'd1);
      wait_done();
      rd(mk(1, 0), v);
      chk("R5 own page byte programmed", {24'b0, v}, 32'h21);
      rd(mk(3, 1), v);
      chk("R5 foreign byte dropped", {24'b0, v}, 32'hFF);
      rd(mk(1, 1), v);
      chk("R5 foreign byte not in own page", {24'b0, v}, 32'hFF);

      // R2 page aliasing in a 1024-byte array
      rd(mk(9, 0), v);
      chk("R2 page 9 aliases page 1", {24'b0, v}, 32'h21);

      // R11 stale marks must not copy page-2 bytes into page 4
      wr(mk(4, 6), 8'h66);
      wait_done();
      rd(mk(4, 6), v);
      chk("R11 loaded byte", {24'b0, v}, 32'h66);
      rd(mk(4, 5), v);
      chk("R11 unloaded offset untouched", {24'b0, v}, 32'hFF);
      rd(mk(4, 3), v);
      chk("R7 R11 other offset untouched", {24'b0, v}, 32'hFF);
      chk("R5 page_err still set", {31'b0, page_err}, 32'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule